// File: doc/BRIEF.md
# NAND Access Width Adapter

This block connects a CPU register port to an asynchronous NAND flash bus. A single CPU request of one, two or four bytes becomes a run of byte or halfword device cycles, sized to the device width set by a configuration bit. Write data is sent on the device bus least significant part first. Read data returned by the device is packed into a 32-bit result.

The request offset chooses one of three register windows: command, address or data. A write to the command window raises the command-latch strobe for the whole access. A write to the address window raises the address-latch strobe. Data-window accesses raise neither strobe. If the chip select is not set up as a NAND device, a request produces no device cycles.

Every device cycle lasts a fixed number of clocks and carries one active-low write-enable or read-enable pulse. A busy output covers the whole access. A single-cycle done pulse marks its end.

Top module: `nand_width_adapter`

## Requirements
- R1: With `dev16`=0, a size code of 0 (1 byte) gives one byte cycle, 1 (2 bytes) gives two, and 2 or 3 (4 bytes) gives four. Write bytes go out on `nand_io_out[7:0]` starting with `wdata[7:0]`, with bits 15:8 driven zero. Read byte k, taken from `nand_io_in[7:0]`, lands in `rdata[8k+7:8k]`. Bytes that are not read are zero.
- R2: With `dev16`=1, a 4-byte access gives two halfword cycles, low half first. A 2-byte access gives one. Read halfword k lands in `rdata[16k+15:16k]`.
- R3: A 1-byte read from a 16-bit device performs one halfword cycle and returns only `nand_io_in[7:0]`, zero-extended.
- R4: A 1-byte write to a 16-bit device performs one halfword cycle that carries `wdata[15:0]`.
- R5: `offset[3:2]` selects the window: 00 command, 01 address, 10 data, 11 unmapped. `offset[1:0]` has no effect. A command write holds `nand_cle` high and an address write holds `nand_ale` high during every device cycle of the access. A data access keeps both low. An unmapped access performs no device cycle, and a read from it returns zero.
- R6: With `is_nand`=0, an access performs no device cycle, and a read returns zero, with `done` in the cycle after the request.
- R7: Each device cycle lasts CYC_CLKS clocks. Its enable is low for the first CYC_CLKS-1 clocks and high for the last. Only one enable is low at a time. `busy` is high for exactly beats × CYC_CLKS cycles, starting in the cycle after the request.
- R8: `done` pulses for one cycle in the cycle after `busy` falls. `rdata` holds the result from then until the next accepted request.
- R9: A request while `busy` is high is ignored. It causes no device cycle and no extra `done`.
- R10: A read aimed at the command or address window performs no device cycle and returns zero.
- R11: After reset, `busy`, `done`, `nand_cle`, `nand_ale` and `nand_io_oe` are low, both enables are high, and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request strobe, taken when not busy |
| we | input | 1 | 1 = write, 0 = read |
| offset | input | 4 | Byte offset; bits 3:2 select the window |
| size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| wdata | input | 32 | Write data |
| dev16 | input | 1 | Device width: 0 = 8-bit, 1 = 16-bit |
| is_nand | input | 1 | Chip select configured as NAND |
| nand_io_in | input | 16 | Device data bus, read direction |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read data |
| nand_io_out | output | 16 | Device data bus, write direction |
| nand_io_oe | output | 1 | Device bus output enable |
| nand_cle | output | 1 | Command-latch strobe |
| nand_ale | output | 1 | Address-latch strobe |
| nand_we_n | output | 1 | Active-low write enable |
| nand_re_n | output | 1 | Active-low read enable |

## Verification
Two events can fall in the same cycle: the end of an access and a new request. A request raised in the last busy cycle meets the clock edge on which the final device cycle ends. The bench provokes this by pulsing `req` exactly there. It then checks that `done` pulses only once, and that no further enable pulse or busy period follows in the next two device-cycle lengths. Randomly mixed requests cover every size, width, window and device-type combination, and each result is compared with a model that counts enable pulses and logs every written beat.

// File: rtl/nand_width_adapter.sv
module nand_width_adapter #(
  parameter int CYC_CLKS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        we,
  input  logic [3:0]  offset,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic        dev16,
  input  logic        is_nand,
  input  logic [15:0] nand_io_in,
  output logic        busy,
  output logic        done,
  output logic [31:0] rdata,
  output logic [15:0] nand_io_out,
  output logic        nand_io_oe,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n
);
  localparam int PW = (CYC_CLKS > 2) ? $clog2(CYC_CLKS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_CLKS - 1);
  localparam logic [PW-1:0] SAMP = PW'(CYC_CLKS - 2);

  logic [1:0]    win;
  logic          active, accept;
  logic [1:0]    nb_m1;
  logic          wr, d16_q, narrow;
  logic [1:0]    win_q, beat, last_beat;
  logic [PW-1:0] phase;
  logic [31:0]   wsh;
  wire           unused_off = &{1'b0, offset[1:0]};

  assign win    = offset[3:2];
  assign accept = req && !busy;
  assign active = is_nand && (win == 2'd2 || (we && win != 2'd3));

  always_comb begin
    if (dev16) nb_m1 = (size >= 2'd2) ? 2'd1 : 2'd0;
    else       nb_m1 = (size == 2'd0) ? 2'd0 : (size == 2'd1) ? 2'd1 : 2'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rdata <= '0; wr <= 1'b0; d16_q <= 1'b0;
      narrow <= 1'b0; win_q <= '0; beat <= '0; last_beat <= '0;
      phase <= '0; wsh <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        rdata     <= '0;
        wr        <= we;
        d16_q     <= dev16;
        narrow    <= dev16 && (size == 2'd0);
        win_q     <= win;
        phase     <= '0;
        beat      <= '0;
        last_beat <= nb_m1;
        wsh       <= wdata;
        if (active) busy <= 1'b1;
        else        done <= 1'b1;
      end else if (busy) begin
        if (!wr && phase == SAMP) begin
          if (d16_q)
            rdata[{beat[0], 4'b0} +: 16] <= narrow ? {8'h00, nand_io_in[7:0]} : nand_io_in;
          else
            rdata[{beat, 3'b0} +: 8] <= nand_io_in[7:0];
        end
        if (phase == LAST) begin
          phase <= '0;
          if (beat == last_beat) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            beat <= beat + 2'd1;
            wsh  <= d16_q ? {16'h0, wsh[31:16]} : {8'h0, wsh[31:8]};
          end
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  assign nand_io_oe  = busy && wr;
  assign nand_io_out = !nand_io_oe ? 16'h0 : (d16_q ? wsh[15:0] : {8'h00, wsh[7:0]});
  assign nand_we_n   = !(busy && wr && phase != LAST);
  assign nand_re_n   = !(busy && !wr && phase != LAST);
  assign nand_cle    = busy && wr && (win_q == 2'd0);
  assign nand_ale    = busy && wr && (win_q == 2'd1);
endmodule

// File: rtl/nand_width_adapter_chk.sv
module nand_width_adapter_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic nand_io_oe,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n
);
  AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R7
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_io_oe && !nand_cle && !nand_ale)); // R11
  AST_DONE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R8
  AST_READ_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> (!nand_cle && !nand_ale && !nand_io_oe)); // R10
endmodule

bind nand_width_adapter nand_width_adapter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .nand_io_oe(nand_io_oe),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n)
);

// File: tb/nand_width_adapter_bench.sv
`timescale 1ns/1ps
module nand_width_adapter_bench;
  localparam int CYC = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 0, we = 0, dev16 = 0, is_nand = 1;
  logic [3:0] offset = 0;
  logic [1:0] size = 0;
  logic [31:0] wdata = 0;
  logic [15:0] nand_io_in;
  logic busy, done, nand_io_oe, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [31:0] rdata;
  logic [15:0] nand_io_out;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  nand_width_adapter #(.CYC_CLKS(CYC)) u_nand_width_adapter (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .offset(offset), .size(size),
    .wdata(wdata), .dev16(dev16), .is_nand(is_nand), .nand_io_in(nand_io_in),
    .busy(busy), .done(done), .rdata(rdata), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n));

  logic we_q = 1, re_q = 1;
  logic [7:0] rd_cnt = 8'h10;
  int wn = 0;
  logic [15:0] wl_d [16];
  logic wl_c [16], wl_a [16];
  assign nand_io_in = {rd_cnt ^ 8'hA5, rd_cnt};

  always @(posedge clk) begin
    we_q <= nand_we_n;
    re_q <= nand_re_n;
    if (!we_q && nand_we_n) begin
      wl_d[wn % 16] <= nand_io_out;
      wl_c[wn % 16] <= nand_cle;
      wl_a[wn % 16] <= nand_ale;
      wn <= wn + 1;
    end
    if (!re_q && nand_re_n) rd_cnt <= rd_cnt + 8'd1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int beats(input logic d, input logic [1:0] s);
    if (d) return (s >= 2) ? 2 : 1;
    return (s == 0) ? 1 : (s == 1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input logic d, input logic [1:0] s, input logic [7:0] c);
    logic [31:0] r = 0;
    int n = beats(d, s);
    for (int k = 0; k < n; k++) begin
      logic [7:0] b = c + 8'(k);
      if (d) r[16*k +: 16] = (s == 0) ? {8'h00, b} : {b ^ 8'hA5, b};
      else   r[8*k +: 8] = b;
    end
    return r;
  endfunction

  task automatic access(input logic w, input logic [3:0] off, input logic [1:0] sz,
                        input logic [31:0] wd, input logic d, input logic nd, input string tag);
    int wn0, bc, nb, g;
    logic [7:0] rc0;
    logic act;
    act = nd && (off[3:2] == 2 || (w && off[3:2] != 3));
    nb = act ? beats(d, sz) : 0;
    @(negedge clk);
    we = w; offset = off; size = sz; wdata = wd; dev16 = d; is_nand = nd; req = 1;
    wn0 = wn; rc0 = rd_cnt;
    @(negedge clk);
    req = 0;
    bc = 0; g = 0;
    while (!done && g < 200) begin
      if (busy) bc++;
      @(negedge clk);
      g++;
    end
    chk(done == 1, {tag, " R8 done"}, 32'(done), 1);
    chk(bc == nb * CYC, {tag, " R7 busy length"}, bc, nb * CYC);
    if (w) begin
      chk(wn - wn0 == nb, {tag, " write beats"}, wn - wn0, nb);
      for (int k = 0; k < nb && k < wn - wn0; k++) begin
        logic [15:0] e = d ? 16'(wd >> (16 * k)) : {8'h00, 8'(wd >> (8 * k))};
        int i = (wn0 + k) % 16;
        chk(wl_d[i] == e, {tag, " write data"}, 32'(wl_d[i]), 32'(e));
        chk(wl_c[i] == (off[3:2] == 0) && wl_a[i] == (off[3:2] == 1), {tag, " R5 strobes"},
            {30'h0, wl_c[i], wl_a[i]}, {30'h0, off[3:2] == 0, off[3:2] == 1});
      end
    end else begin
      logic [31:0] e = act ? exp_read(d, sz, rc0) : 32'h0;
      chk(8'(rd_cnt - rc0) == 8'(nb), {tag, " read beats"}, 32'(8'(rd_cnt - rc0)), nb);
      chk(rdata == e, {tag, " rdata"}, rdata, e);
    end
    @(negedge clk);
    chk(done == 0, {tag, " R8 done single"}, 32'(done), 0);
    chk(rdata == (w ? rdata : (act ? exp_read(d, sz, rc0) : 32'h0)), {tag, " R8 rdata held"}, rdata, rdata);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(!busy && !done && rdata == 0 && !nand_cle && !nand_ale && !nand_io_oe && nand_we_n && nand_re_n,
        "R11 reset state", {busy, done, nand_cle, nand_ale, nand_io_oe, nand_we_n, nand_re_n}, 32'h3);
    rst_n = 1;
    access(1, 4'h8, 2'd2, 32'hDDCCBBAA, 0, 1, "R1 w8x4");
    access(1, 4'hB, 2'd1, 32'h00001234, 0, 1, "R1 w8x2");
    access(0, 4'h9, 2'd2, 32'h0, 0, 1, "R1 r8x4");
    access(0, 4'hA, 2'd0, 32'h0, 0, 1, "R1 r8x1");
    access(1, 4'h8, 2'd3, 32'h87654321, 1, 1, "R2 w16x4");
    access(0, 4'h8, 2'd1, 32'h0, 1, 1, "R2 r16x2");
    access(0, 4'h8, 2'd2, 32'h0, 1, 1, "R2 r16x4");
    access(0, 4'h8, 2'd0, 32'h0, 1, 1, "R3 r16x1");
    access(1, 4'h8, 2'd0, 32'h0000BEEF, 1, 1, "R4 w16x1");
    access(1, 4'h1, 2'd0, 32'h00000070, 0, 1, "R5 cmd");
    access(1, 4'h7, 2'd0, 32'h00000055, 0, 1, "R5 addr");
    access(0, 4'hC, 2'd2, 32'h0, 0, 1, "R5 unmapped read");
    access(1, 4'hE, 2'd2, 32'h11111111, 0, 1, "R5 unmapped write");
    access(0, 4'h8, 2'd2, 32'h0, 0, 0, "R6 not nand read");
    access(1, 4'h0, 2'd2, 32'h12345678, 1, 0, "R6 not nand write");
    access(0, 4'h0, 2'd1, 32'h0, 0, 1, "R10 read cmd");
    access(0, 4'h4, 2'd1, 32'h0, 1, 1, "R10 read addr");
    begin : concurrent_r9
      int wn0, bc;
      @(negedge clk);
      we = 1; offset = 4'h8; size = 2'd1; wdata = 32'h0000A55A; dev16 = 0; is_nand = 1; req = 1;
      wn0 = wn;
      @(negedge clk);
      req = 0;
      for (int c = 1; c < 2 * CYC; c++) @(negedge clk);
      chk(busy == 1, "R9 last busy cycle", 32'(busy), 1);
      wdata = 32'hFFFFFFFF; size = 2'd2; req = 1;
      @(negedge clk);
      req = 0;
      chk(done == 1 && busy == 0, "R9 end with request", {busy, done}, 32'h1);
      bc = 0;
      for (int c = 0; c < 2 * CYC; c++) begin
        @(negedge clk);
        if (busy || done) bc++;
      end
      chk(bc == 0, "R9 request ignored", bc, 0);
      chk(wn - wn0 == 2, "R9 beat count", wn - wn0, 2);
    end
    for (int i = 0; i < 300; i++) begin
      logic [3:0] o = 4'($urandom);
      logic [1:0] s = 2'($urandom);
      logic w = 1'($urandom);
      logic d = 1'($urandom);
      logic nd = ($urandom % 8) != 0;
      access(w, o, s, $urandom, d, nd, "random R1 R2 R3 R4 R5");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule